// File: doc/BRIEF.md
# DMA Event and Interrupt Unit

This unit keeps the event and interrupt state that all channels of a multi-channel DMA engine share. A channel can signal an event or wait for one. Both requests carry an operand byte whose bits 7:3 select the event. For each event, a software-written enable bit chooses what a signal does. With the bit set, the signal becomes a level interrupt line held in the interrupt status. With the bit clear, it sets a raw event flag that waiting channels consume. Software reads the status and clears interrupts through a small 32-bit register window.

Each operand is checked before it is used. An event number outside the configured range gives an operand fault. A non-secure requester that names an event missing from the non-secure event mask gives a permission fault. Fault codes from these checks and from an external fault port build up in a per-channel fault-type word. The unit counts the channels in the fault state, and a single abort line stays high while that count is above zero. A kill returns a channel to the ready state.

Each channel runs its own state machine with three states: READY (state code 1), WAIT_EV (code 4) and FAULT (code 15). The transitions are:
- READY to WAIT_EV on an accepted wait whose event is not yet consumable.
- READY stays in READY, with a wake pulse, on an accepted wait that consumes a pending flag at once.
- READY or WAIT_EV to FAULT on any fault code.
- WAIT_EV to READY, with a wake pulse, when its event is consumed.
- Any state to READY on a kill.

Top module: `dma_evirq_unit`

## Requirements
- R1: After reset, the enable, raw event and interrupt status are all zero, every interrupt line and the abort line are low, every channel reports state code 1, and every fault-type word is zero.
- R2: The event number is operand bits 7:3. A number not below NUM_EV sets fault bit 1 (value 0x2) and drops the request. Only bit 1 is set in that case, even for a non-secure requester.
- R3: A non-secure request (ns=1) for an in-range event whose bit is clear in ns_ev_mask sets fault bit 5 (value 0x20) and drops the request. A non-secure request for an event whose mask bit is set proceeds normally.
- R4: A signal for an enabled event sets its interrupt status bit, and the matching interrupt line is high one cycle after the request. A signal for a disabled event sets the raw event bit instead and leaves the interrupt lines as they were.
- R5: A wait is satisfied only when the raw bit is set and the enable bit is clear. If that holds at the request, the channel stays in READY, its wake bit pulses for one cycle on the next cycle, and the raw bit is consumed. Otherwise the channel enters WAIT_EV (code 4). A signal for an enabled event never releases a waiter.
- R6: One signal releases every channel waiting on that event together. Their wake bits pulse and their states return to 1 two cycles after the signal request, and the raw bit is cleared.
- R7: A write to the clear register removes (written value AND enable) from both the raw and the interrupt status. The affected interrupt lines drop on the next cycle. Bits whose enable is clear are left untouched.
- R8: The register window is as follows. Enable is at 0x020, read/write, and only its low NUM_EV bits are kept. Raw status is at 0x024 and interrupt status at 0x028, both read-only, and writes to them are ignored. Clear is at 0x02C and reads zero. Read data appears one cycle after the read strobe.
- R9: A fault moves a channel to state code 15. Fault codes OR into its fault-type word, including codes from the external fault port. Signal and wait requests from a channel that is not in READY are ignored.
- R10: The abort line is high exactly while at least one channel is in FAULT. A second fault on a channel already in FAULT does not count that channel twice. A kill of a faulting channel lowers the count.
- R11: A kill returns a channel from any state to READY (code 1) and clears its fault-type word. Killing a channel that is waiting, rather than faulting, leaves the abort line unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_req | input | 1 | Signal-event request |
| sig_ch | input | CHW | Channel issuing the signal |
| sig_ns | input | 1 | Signal requester is non-secure |
| sig_opnd | input | 8 | Signal operand byte, event in bits 7:3 |
| wait_req | input | 1 | Wait-for-event request |
| wait_ch | input | CHW | Channel issuing the wait |
| wait_ns | input | 1 | Wait requester is non-secure |
| wait_opnd | input | 8 | Wait operand byte, event in bits 7:3 |
| ns_ev_mask | input | NUM_EV | Events that non-secure channels may use |
| fault_req | input | 1 | External fault notification |
| fault_ch | input | CHW | Channel that the external fault names |
| fault_code | input | 32 | Fault bits to OR into that channel |
| kill_req | input | 1 | Kill request |
| kill_ch | input | CHW | Channel to kill |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |
| irq_o | output | NUM_EV | Interrupt lines, one per event |
| abort_o | output | 1 | High while any channel is faulting |
| wake_o | output | NUM_CH | One-cycle wake pulse per channel |
| ch_state_o | output | NUM_CH*4 | State code per channel |
| fault_type_o | output | NUM_CH*32 | Fault-type word per channel |

## Verification
Every output comes from a register. Interrupt lines, abort, state codes, fault words and a wake on an immediately satisfied wait are due one cycle after the request. Register read data is due one cycle after the read strobe. A waiter released by another channel's signal is due two cycles after the signal, because the raw flag is registered first and consumed on the next edge. Each stimulus task records its expected values together with the exact cycle number at which they are due. The monitor compares each value on the falling edge of that cycle and no earlier.

// File: rtl/dmaev_pkg.sv
package dmaev_pkg;

    typedef enum logic [3:0] {
        CH_READY   = 4'd1,
        CH_WAIT_EV = 4'd4,
        CH_FAULT   = 4'd15
    } ch_state_e;

    localparam logic [31:0] FLT_OPERAND = 32'h0000_0002;
    localparam logic [31:0] FLT_EV_PERM = 32'h0000_0020;

    localparam logic [11:0] OFS_ENABLE = 12'h020;
    localparam logic [11:0] OFS_RAW    = 12'h024;
    localparam logic [11:0] OFS_MASKED = 12'h028;
    localparam logic [11:0] OFS_CLEAR  = 12'h02C;

endpackage

// File: rtl/dmaev_opchk.sv
module dmaev_opchk
    import dmaev_pkg::*;
#(
    parameter int NUM_EV = 16
) (
    input  logic [7:0]        opnd,
    input  logic              ns,
    input  logic [NUM_EV-1:0] ns_mask,
    output logic [4:0]        ev_id,
    output logic [31:0]       flt
);
    logic [31:0] mask_ext;
    logic        unused_lo;

    assign mask_ext  = 32'(ns_mask);
    assign unused_lo = ^opnd[2:0];

    // Range is checked first; the permission check only applies to valid events
    always_comb begin
        ev_id = opnd[7:3];
        flt   = '0;
        if (32'(ev_id) >= NUM_EV) begin
            flt = FLT_OPERAND;
        end else if (ns && !mask_ext[ev_id]) begin
            flt = FLT_EV_PERM;
        end
    end

endmodule

// File: rtl/dmaev_chan.sv
module dmaev_chan
    import dmaev_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        do_wait,
    input  logic [4:0]  wait_ev,
    input  logic        wait_hit,
    input  logic [31:0] take_vec,
    input  logic [31:0] flt_in,
    input  logic        kill,
    output logic [3:0]  state_o,
    output logic        ready_o,
    output logic        waiting_o,
    output logic        fault_o,
    output logic [4:0]  wev_o,
    output logic        wake_o,
    output logic [31:0] ftype_o,
    output logic        enter_o,
    output logic        leave_o
);
    ch_state_e   st_q, st_d;
    logic [4:0]  wev_q, wev_d;
    logic        wake_q, wake_d;
    logic [31:0] ftype_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= CH_READY;
            wev_q  <= '0;
            wake_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            wev_q  <= wev_d;
            wake_q <= wake_d;
        end
    end

    // Next state and transition outputs
    always_comb begin
        st_d    = st_q;
        wev_d   = wev_q;
        wake_d  = 1'b0;
        enter_o = 1'b0;
        leave_o = 1'b0;
        unique case (st_q)
            CH_READY: begin
                if (kill) begin
                    st_d = CH_READY;
                end else if (|flt_in) begin
                    st_d    = CH_FAULT;
                    enter_o = 1'b1;
                end else if (do_wait) begin
                    if (wait_hit) begin
                        wake_d = 1'b1;
                    end else begin
                        st_d  = CH_WAIT_EV;
                        wev_d = wait_ev;
                    end
                end
            end
            CH_WAIT_EV: begin
                if (kill) begin
                    st_d = CH_READY;
                end else if (|flt_in) begin
                    st_d    = CH_FAULT;
                    enter_o = 1'b1;
                end else if (take_vec[wev_q]) begin
                    st_d   = CH_READY;
                    wake_d = 1'b1;
                end
            end
            CH_FAULT: begin
                if (kill) begin
                    st_d    = CH_READY;
                    leave_o = 1'b1;
                end
            end
            default: st_d = CH_READY;
        endcase
    end

    // Fault word accumulates until a kill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftype_q <= '0;
        end else if (kill) begin
            ftype_q <= '0;
        end else begin
            ftype_q <= ftype_q | flt_in;
        end
    end

    assign state_o   = st_q;
    assign ready_o   = (st_q == CH_READY);
    assign waiting_o = (st_q == CH_WAIT_EV);
    assign fault_o   = (st_q == CH_FAULT);
    assign wev_o     = wev_q;
    assign wake_o    = wake_q;
    assign ftype_o   = ftype_q;

    AST_FAULT_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_FAULT) |-> (ftype_q != 32'd0)); // R9

    AST_WAKE_FROM_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> ($past(st_q) == CH_WAIT_EV || $past(do_wait))); // R5

endmodule

// File: rtl/dmaev_evregs.sv
module dmaev_evregs
    import dmaev_pkg::*;
#(
    parameter int NUM_EV = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sig_go,
    input  logic [4:0]        sig_ev,
    input  logic [NUM_EV-1:0] take,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [11:0]       reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [NUM_EV-1:0] en_o,
    output logic [NUM_EV-1:0] raw_o,
    output logic [NUM_EV-1:0] irq_o,
    output logic [31:0]       rdata_o
);
    logic [NUM_EV-1:0] en_q, raw_q, ist_q, sig_vec, clr_vec;
    logic              clr_wr, unused_hi;

    assign clr_wr    = reg_wr && (reg_addr == OFS_CLEAR);
    assign unused_hi = ^reg_wdata;

    always_comb begin
        sig_vec = '0;
        if (sig_go) sig_vec = NUM_EV'(32'd1 << sig_ev);
        clr_vec = '0;
        if (clr_wr) clr_vec = reg_wdata[NUM_EV-1:0] & en_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            raw_q   <= '0;
            ist_q   <= '0;
            rdata_o <= '0;
        end else begin
            if (reg_wr && reg_addr == OFS_ENABLE) en_q <= reg_wdata[NUM_EV-1:0];
            raw_q <= (raw_q & ~take & ~clr_vec) | (sig_vec & ~en_q);
            ist_q <= (ist_q & ~clr_vec) | (sig_vec & en_q);
            if (reg_rd) begin
                case (reg_addr)
                    OFS_ENABLE: rdata_o <= 32'(en_q);
                    OFS_RAW:    rdata_o <= 32'(raw_q);
                    OFS_MASKED: rdata_o <= 32'(ist_q);
                    default:    rdata_o <= '0;
                endcase
            end
        end
    end

    assign en_o  = en_q;
    assign raw_o = raw_q;
    assign irq_o = ist_q;

    AST_IRQ_NEEDS_SIGNAL: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ist_q & ~$past(ist_q))) |-> $past(sig_go)); // R4

    AST_IRQ_DROP_BY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ist_q) & ~ist_q)) |-> $past(clr_wr)); // R7

endmodule

// File: rtl/dmaev_abort.sv
module dmaev_abort #(
    parameter  int NUM_CH = 8,
    localparam int CNTW   = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] enter_vec,
    input  logic [NUM_CH-1:0] leave_vec,
    output logic              abort_o
);
    logic [CNTW-1:0] cnt_q, n_in, n_out;

    always_comb begin
        n_in  = '0;
        n_out = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            n_in  = n_in + CNTW'(enter_vec[i]);
            n_out = n_out + CNTW'(leave_vec[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + n_in - n_out;
    end

    assign abort_o = (cnt_q != '0);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cnt_q) <= NUM_CH); // R10

endmodule

// File: rtl/dma_evirq_unit.sv
module dma_evirq_unit
    import dmaev_pkg::*;
#(
    parameter  int NUM_CH = 8,
    parameter  int NUM_EV = 16,
    localparam int CHW    = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sig_req,
    input  logic [CHW-1:0]       sig_ch,
    input  logic                 sig_ns,
    input  logic [7:0]           sig_opnd,
    input  logic                 wait_req,
    input  logic [CHW-1:0]       wait_ch,
    input  logic                 wait_ns,
    input  logic [7:0]           wait_opnd,
    input  logic [NUM_EV-1:0]    ns_ev_mask,
    input  logic                 fault_req,
    input  logic [CHW-1:0]       fault_ch,
    input  logic [31:0]          fault_code,
    input  logic                 kill_req,
    input  logic [CHW-1:0]       kill_ch,
    input  logic                 reg_rd,
    input  logic                 reg_wr,
    input  logic [11:0]          reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic [NUM_EV-1:0]    irq_o,
    output logic                 abort_o,
    output logic [NUM_CH-1:0]    wake_o,
    output logic [NUM_CH*4-1:0]  ch_state_o,
    output logic [NUM_CH*32-1:0] fault_type_o
);
    logic [4:0]        sig_ev, wait_ev;
    logic [31:0]       sig_flt, wait_flt;
    logic [NUM_CH-1:0] ready_vec, waiting_vec, fault_vec, enter_vec, leave_vec;
    logic [NUM_CH*5-1:0] wev_flat;
    logic              sig_acc, wait_acc, sig_go, wait_go;
    logic [NUM_EV-1:0] en_v, raw_v, want_v, take_v;
    logic [31:0]       take_ext;

    dmaev_opchk #(.NUM_EV(NUM_EV)) u_chk_sig (
        .opnd(sig_opnd), .ns(sig_ns), .ns_mask(ns_ev_mask),
        .ev_id(sig_ev), .flt(sig_flt)
    );

    dmaev_opchk #(.NUM_EV(NUM_EV)) u_chk_wait (
        .opnd(wait_opnd), .ns(wait_ns), .ns_mask(ns_ev_mask),
        .ev_id(wait_ev), .flt(wait_flt)
    );

    // Only READY channels may issue; the signal port wins on a shared channel
    assign sig_acc  = sig_req && ready_vec[sig_ch];
    assign wait_acc = wait_req && ready_vec[wait_ch] && !(sig_acc && sig_ch == wait_ch);
    assign sig_go   = sig_acc && (sig_flt == 32'd0);
    assign wait_go  = wait_acc && (wait_flt == 32'd0);

    // Events some channel wants to consume this cycle
    always_comb begin
        want_v = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (waiting_vec[c]) want_v = want_v | NUM_EV'(32'd1 << wev_flat[c*5 +: 5]);
        end
        if (wait_go) want_v = want_v | NUM_EV'(32'd1 << wait_ev);
    end

    assign take_v   = raw_v & ~en_v & want_v;
    assign take_ext = 32'(take_v);

    dmaev_evregs #(.NUM_EV(NUM_EV)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .sig_go(sig_go), .sig_ev(sig_ev), .take(take_v),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .en_o(en_v), .raw_o(raw_v), .irq_o(irq_o), .rdata_o(reg_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [31:0] flt_in;
        logic [3:0]  st;

        always_comb begin
            flt_in = '0;
            if (sig_acc && sig_ch == CHW'(c))     flt_in = flt_in | sig_flt;
            if (wait_acc && wait_ch == CHW'(c))   flt_in = flt_in | wait_flt;
            if (fault_req && fault_ch == CHW'(c)) flt_in = flt_in | fault_code;
        end

        dmaev_chan u_ch (
            .clk(clk), .rst_n(rst_n),
            .do_wait(wait_go && wait_ch == CHW'(c)),
            .wait_ev(wait_ev), .wait_hit(take_ext[wait_ev]),
            .take_vec(take_ext), .flt_in(flt_in),
            .kill(kill_req && kill_ch == CHW'(c)),
            .state_o(st), .ready_o(ready_vec[c]), .waiting_o(waiting_vec[c]),
            .fault_o(fault_vec[c]), .wev_o(wev_flat[c*5 +: 5]), .wake_o(wake_o[c]),
            .ftype_o(fault_type_o[c*32 +: 32]),
            .enter_o(enter_vec[c]), .leave_o(leave_vec[c])
        );

        assign ch_state_o[c*4 +: 4] = st;
    end

    dmaev_abort #(.NUM_CH(NUM_CH)) u_abort (
        .clk(clk), .rst_n(rst_n),
        .enter_vec(enter_vec), .leave_vec(leave_vec), .abort_o(abort_o)
    );

    AST_ABORT_TRACKS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o == (|fault_vec)); // R10

endmodule

// File: tb/dma_evirq_unit_tb_top.sv
module dma_evirq_unit_tb_top;
    localparam int NCH = 8;
    localparam int NEV = 16;
    localparam int CW  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              sig_req = 0, sig_ns = 0, wait_req = 0, wait_ns = 0;
    logic [CW-1:0]     sig_ch = 0, wait_ch = 0, fault_ch = 0, kill_ch = 0;
    logic [7:0]        sig_opnd = 0, wait_opnd = 0;
    logic [NEV-1:0]    ns_ev_mask = 16'h00FF;
    logic              fault_req = 0, kill_req = 0, reg_rd = 0, reg_wr = 0;
    logic [31:0]       fault_code = 0, reg_wdata = 0;
    logic [11:0]       reg_addr = 0;
    logic [31:0]       reg_rdata;
    logic [NEV-1:0]    irq_o;
    logic              abort_o;
    logic [NCH-1:0]    wake_o;
    logic [NCH*4-1:0]  ch_state_o;
    logic [NCH*32-1:0] fault_type_o;

    dma_evirq_unit #(.NUM_CH(NCH), .NUM_EV(NEV)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .sig_req(sig_req), .sig_ch(sig_ch), .sig_ns(sig_ns), .sig_opnd(sig_opnd),
        .wait_req(wait_req), .wait_ch(wait_ch), .wait_ns(wait_ns), .wait_opnd(wait_opnd),
        .ns_ev_mask(ns_ev_mask),
        .fault_req(fault_req), .fault_ch(fault_ch), .fault_code(fault_code),
        .kill_req(kill_req), .kill_ch(kill_ch),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o), .abort_o(abort_o), .wake_o(wake_o),
        .ch_state_o(ch_state_o), .fault_type_o(fault_type_o)
    );

    // Probe ids: 0 irq, 1 abort, 2 wake, 3 rdata, 4 state code, 5 fault word
    typedef struct {
        int          due;
        int          probe;
        int          idx;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t sbq[$];
    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] probe_val(int p, int i);
        case (p)
            0: return 32'(irq_o);
            1: return {31'd0, abort_o};
            2: return 32'(wake_o);
            3: return reg_rdata;
            4: return 32'(ch_state_o[i*4 +: 4]);
            5: return fault_type_o[i*32 +: 32];
            default: return 32'd0;
        endcase
    endfunction

    // Monitor: compare every item whose cycle has come
    always @(negedge clk) begin : mon
        logic [31:0] got;
        for (int k = sbq.size() - 1; k >= 0; k--) begin
            if (sbq[k].due <= cyc) begin
                got = probe_val(sbq[k].probe, sbq[k].idx);
                n_cmp++;
                if (got !== sbq[k].exp) begin
                    n_bad++;
                    $display("FAIL %s probe=%0d idx=%0d cycle=%0d actual=%h expected=%h",
                             sbq[k].req, sbq[k].probe, sbq[k].idx, cyc, got, sbq[k].exp);
                end
                sbq.delete(k);
            end
        end
    end

    task automatic expect_at(int dly, int p, int i, logic [31:0] e, string r);
        item_t it;
        it.due = cyc + dly; it.probe = p; it.idx = i; it.exp = e; it.req = r;
        sbq.push_back(it);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_expect(logic [11:0] a, logic [31:0] e, string r);
        reg_rd = 1'b1; reg_addr = a;
        expect_at(1, 3, 0, e, r);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic sig(int ch, logic ns, logic [7:0] op);
        sig_req = 1'b1; sig_ch = CW'(ch); sig_ns = ns; sig_opnd = op;
        @(negedge clk);
        sig_req = 1'b0;
    endtask

    task automatic wt(int ch, logic ns, logic [7:0] op);
        wait_req = 1'b1; wait_ch = CW'(ch); wait_ns = ns; wait_opnd = op;
        @(negedge clk);
        wait_req = 1'b0;
    endtask

    task automatic kill(int ch);
        kill_req = 1'b1; kill_ch = CW'(ch);
        @(negedge clk);
        kill_req = 1'b0;
    endtask

    task automatic xfault(int ch, logic [31:0] code);
        fault_req = 1'b1; fault_ch = CW'(ch); fault_code = code;
        @(negedge clk);
        fault_req = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : driver
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        expect_at(1, 0, 0, 32'h0, "R1");
        expect_at(1, 1, 0, 32'h0, "R1");
        expect_at(1, 4, 0, 32'h1, "R1");
        expect_at(1, 4, 7, 32'h1, "R1");
        expect_at(1, 5, 3, 32'h0, "R1");
        rd_expect(12'h020, 32'h0, "R1");
        rd_expect(12'h024, 32'h0, "R1");

        // R8 enable keeps only the low event bits
        wr(12'h020, 32'hFFFF_0003);
        rd_expect(12'h020, 32'h3, "R8");

        // R4 enabled event becomes an interrupt
        expect_at(1, 0, 0, 32'h2, "R4");
        sig(2, 1'b0, 8'h08);
        rd_expect(12'h028, 32'h2, "R4");
        rd_expect(12'h024, 32'h0, "R4");

        // R4 disabled event goes to raw status
        expect_at(1, 0, 0, 32'h2, "R4");
        sig(3, 1'b0, 8'h28);
        rd_expect(12'h024, 32'h20, "R4");

        // R8 status writes ignored, clear reads zero
        wr(12'h024, 32'h0);
        wr(12'h028, 32'h0);
        rd_expect(12'h024, 32'h20, "R8");
        rd_expect(12'h028, 32'h2, "R8");
        rd_expect(12'h02C, 32'h0, "R8");

        // R7 clear only touches enabled bits
        expect_at(1, 0, 0, 32'h0, "R7");
        wr(12'h02C, 32'hFFFF_FFFF);
        rd_expect(12'h028, 32'h0, "R7");
        rd_expect(12'h024, 32'h20, "R7");

        // R5 wait on a pending raw event resumes at once
        expect_at(1, 2, 0, 32'h10, "R5");
        expect_at(2, 2, 0, 32'h0, "R5");
        expect_at(1, 4, 4, 32'h1, "R5");
        wt(4, 1'b0, 8'h28);
        rd_expect(12'h024, 32'h0, "R5");

        // R6 two waiters on event 6 released by one signal
        expect_at(1, 4, 0, 32'h4, "R5");
        wt(0, 1'b0, 8'h30);
        expect_at(1, 4, 1, 32'h4, "R6");
        wt(1, 1'b0, 8'h30);
        expect_at(1, 4, 0, 32'h4, "R6");
        expect_at(2, 2, 0, 32'h3, "R6");
        expect_at(2, 4, 0, 32'h1, "R6");
        expect_at(2, 4, 1, 32'h1, "R6");
        expect_at(3, 2, 0, 32'h0, "R6");
        sig(5, 1'b0, 8'h30);
        idle(1);
        rd_expect(12'h024, 32'h0, "R6");

        // R5 signal of an enabled event does not release a waiter
        expect_at(1, 4, 6, 32'h4, "R5");
        wt(6, 1'b0, 8'h00);
        expect_at(1, 0, 0, 32'h1, "R4");
        expect_at(2, 4, 6, 32'h4, "R5");
        expect_at(3, 2, 0, 32'h0, "R5");
        sig(5, 1'b0, 8'h00);
        idle(2);
        // R11 kill of a waiter, abort untouched
        expect_at(1, 4, 6, 32'h1, "R11");
        expect_at(1, 1, 0, 32'h0, "R11");
        kill(6);
        expect_at(1, 0, 0, 32'h0, "R7");
        wr(12'h02C, 32'h1);

        // R2 out-of-range event, non-secure: operand fault only
        expect_at(1, 4, 7, 32'hF, "R9");
        expect_at(1, 5, 7, 32'h2, "R2");
        expect_at(1, 1, 0, 32'h1, "R10");
        expect_at(1, 0, 0, 32'h0, "R2");
        sig(7, 1'b1, 8'hA0);

        // R3 non-secure wait on a masked event
        expect_at(1, 5, 2, 32'h20, "R3");
        expect_at(1, 4, 2, 32'hF, "R3");
        wt(2, 1'b1, 8'h48);

        // R3 non-secure signal on a permitted event
        expect_at(1, 4, 3, 32'h1, "R3");
        expect_at(1, 5, 3, 32'h0, "R3");
        sig(3, 1'b1, 8'h18);
        rd_expect(12'h024, 32'h08, "R3");

        // R9 request from a faulting channel ignored
        sig(7, 1'b0, 8'h20);
        rd_expect(12'h024, 32'h08, "R9");

        // R9 fault codes accumulate
        expect_at(1, 5, 7, 32'h82, "R9");
        expect_at(1, 4, 7, 32'hF, "R9");
        xfault(7, 32'h80);

        // R10 abort held until the last faulting channel is killed
        expect_at(1, 1, 0, 32'h1, "R10");
        expect_at(1, 4, 2, 32'h1, "R11");
        expect_at(1, 5, 2, 32'h0, "R11");
        kill(2);
        expect_at(1, 1, 0, 32'h0, "R10");
        expect_at(1, 4, 7, 32'h1, "R11");
        expect_at(1, 5, 7, 32'h0, "R11");
        kill(7);

        idle(4);
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sbq.size());
        end
        summary();
        $finish;
    end

endmodule